// File: doc/BRIEF.md
# Flash block-protect region decoder

This block evaluates the write-protect setting of a serial NOR flash. It takes the two status bytes of the device as plain register values, the device size in bytes and a query range. From the protect-level field, the top/bottom select bit and the complement bit, it computes the protected byte range as an offset and a size. It also reports whether the query range lies entirely inside that protected range.

The protected size grows in powers of two from a granularity that is set by a parameter. It is clipped to the device size. The complement bit turns the protected part into the remainder of the array and moves it to the opposite end. A parameter selects one of two status layouts: a 3-level-bit layout that also carries a sector-mode bit, or a 4-level-bit layout without one. The 3-bit layout does not decode sector-granular protection; it reports an error instead. The block is combinational with one register stage at its outputs. Reading the status bytes from the flash is done elsewhere.

Top module: `flashWpDecoder`

## Requirements
- R1: While reset (`rstN` low) is asserted, `protOffset`, `protSize`, `covered` and `protErr` are all 0.
- R2: A protect-level field of 0 with the complement bit clear gives `protSize` = 0 and `covered` = 0.
- R3: A nonzero level L gives a raw size of (1 << GRAN_SHIFT) << (L-1) bytes. This raw size is limited to `flashBytes`.
- R4: When the complement bit (bit 6 of `statusHi`) is 1, `protSize` is `flashBytes` minus the limited raw size, and the top/bottom sense is inverted.
- R5: After any inversion, a bottom flag of 1 gives `protOffset` = 0, and a bottom flag of 0 gives `protOffset` = `flashBytes` - `protSize`.
- R6: The level field is `statusLo[4:2]` with the bottom flag in `statusLo[5]` when PROT_BITS = 3. It is `statusLo[5:2]` with the bottom flag in `statusLo[6]` when PROT_BITS = 4.
- R7: With PROT_BITS = 3, `statusLo[6]` = 1 (sector mode) gives `protErr` = 1, with `protOffset`, `protSize` and `covered` all 0. With PROT_BITS = 4 that bit is the bottom flag and raises no error.
- R8: `covered` is 1 exactly when `protSize` is nonzero, `qryStart` >= `protOffset`, and `qryStart` + `qryLen` <= `protOffset` + `protSize` (computed without overflow).
- R9: Outputs show the inputs sampled at the previous rising clock edge; a change on the inputs does not reach the outputs before that edge.
- R10: Bits 0, 1 and 7 of `statusLo` and all bits of `statusHi` other than bit 6 have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| statusLo | input | 8 | First status byte (level field, bottom flag, sector bit) |
| statusHi | input | 8 | Second status byte (complement in bit 6) |
| flashBytes | input | 32 | Device size in bytes |
| qryStart | input | 32 | First byte of the query range |
| qryLen | input | 32 | Length of the query range in bytes |
| protOffset | output | 32 | First protected byte |
| protSize | output | 32 | Protected length in bytes |
| covered | output | 1 | Query range lies wholly inside the protected range |
| protErr | output | 1 | Sector mode set; region not decoded |

## Verification
A wrong field extraction or a wrong bottom/complement sense shows up one clock after the inputs are applied. It appears as a wrong `protOffset`, or as the region sitting at the wrong end of the array, and `covered` then flips for queries at either end. A faulty shift or a missing size limit gives a `protSize` that is a wrong power of two or larger than `flashBytes`. Checking the range boundaries exactly, one byte inside and one byte outside, catches off-by-one errors in the coverage compare on the same cycle.

// File: rtl/wpDecodePkg.sv
package wpDecodePkg;

  // Strobes from the field decoder to the size/offset datapath
  typedef struct packed {
    logic fieldZero;  // level field is zero
    logic sectorErr;  // sector mode requested, not decodable
    logic cmpSet;     // complement the protected size
    logic bottom;     // final sense after complement: region anchored at 0
  } wpStrobes_t;

  localparam int ADDR_W = 32;

endpackage

// File: rtl/wpCtrl.sv
module wpCtrl
  import wpDecodePkg::*;
#(
  parameter int PROT_BITS = 3
) (
  input  logic [7:0]           statusLo,
  input  logic [7:0]           statusHi,
  output logic [PROT_BITS-1:0] protField,
  output wpStrobes_t           ctl
);

  logic tbBit;
  logic secBit;
  logic cmpBit;
  logic unusedBits;

  assign cmpBit = statusHi[6];

  generate
    if (PROT_BITS == 4) begin : g_wide
      assign protField  = statusLo[5:2];
      assign tbBit      = statusLo[6];
      assign secBit     = 1'b0;
      assign unusedBits = ^{statusLo[7], statusLo[1:0], statusHi[7], statusHi[5:0]};
    end else begin : g_narrow
      assign protField  = statusLo[4:2];
      assign tbBit      = statusLo[5];
      assign secBit     = statusLo[6];
      assign unusedBits = ^{statusLo[7], statusLo[1:0], statusHi[7], statusHi[5:0]};
    end
  endgenerate

  always_comb begin
    ctl.fieldZero = (protField == '0);
    ctl.sectorErr = secBit;
    ctl.cmpSet    = cmpBit;
    ctl.bottom    = tbBit ^ cmpBit;
  end

endmodule

// File: rtl/wpDatapath.sv
module wpDatapath
  import wpDecodePkg::*;
#(
  parameter int PROT_BITS  = 3,
  parameter int GRAN_SHIFT = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wpStrobes_t           ctl,
  input  logic [PROT_BITS-1:0] protField,
  input  logic [ADDR_W-1:0]    flashBytes,
  input  logic [ADDR_W-1:0]    qryStart,
  input  logic [ADDR_W-1:0]    qryLen,
  output logic [ADDR_W-1:0]    protOffset,
  output logic [ADDR_W-1:0]    protSize,
  output logic                 covered,
  output logic                 protErr
);

  localparam int WIDE_W = 2 * ADDR_W;
  localparam logic [WIDE_W-1:0] GRAN_BYTES = WIDE_W'(1) << GRAN_SHIFT;

  logic [PROT_BITS-1:0] shAmt;
  logic [WIDE_W-1:0]    rawWide;
  logic [ADDR_W-1:0]    satSize;
  logic [ADDR_W-1:0]    nxtSize;
  logic [ADDR_W-1:0]    nxtOffset;
  logic [ADDR_W:0]      qEnd;
  logic [ADDR_W:0]      rEnd;
  logic                 nxtCovered;

  always_comb begin
    shAmt   = protField - PROT_BITS'(1);
    rawWide = ctl.fieldZero ? '0 : (GRAN_BYTES << shAmt);
    satSize = (rawWide > {{ADDR_W{1'b0}}, flashBytes}) ? flashBytes : rawWide[ADDR_W-1:0];
    nxtSize = ctl.cmpSet ? (flashBytes - satSize) : satSize;
    nxtOffset = ctl.bottom ? '0 : (flashBytes - nxtSize);
    qEnd = {1'b0, qryStart} + {1'b0, qryLen};
    rEnd = {1'b0, nxtOffset} + {1'b0, nxtSize};
    nxtCovered = (nxtSize != '0) && (qryStart >= nxtOffset) && (qEnd <= rEnd);
    if (ctl.sectorErr) begin
      nxtSize    = '0;
      nxtOffset  = '0;
      nxtCovered = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      protOffset <= '0;
      protSize   <= '0;
      covered    <= 1'b0;
      protErr    <= 1'b0;
    end else begin
      protOffset <= nxtOffset;
      protSize   <= nxtSize;
      covered    <= nxtCovered;
      protErr    <= ctl.sectorErr;
    end
  end

  // R3: protected size never exceeds the device size sampled with it
  p_size_le_dev_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (protSize <= $past(flashBytes)));

  // R5: the region ends inside the device
  p_region_fits_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (({1'b0, protOffset} + {1'b0, protSize}) <= {1'b0, $past(flashBytes)}));

  // R8: coverage implies a nonempty region
  p_covered_nonempty_r8: assert property (@(posedge clk) disable iff (!rstN)
    covered |-> (protSize != '0));

  // R7: an error carries an empty region
  p_error_empty_r7: assert property (@(posedge clk) disable iff (!rstN)
    protErr |-> (protSize == '0 && protOffset == '0 && !covered));

  // R2: zero level without complement yields nothing protected
  p_zero_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.fieldZero && !ctl.cmpSet) |=> (protSize == '0));

endmodule

// File: rtl/flashWpDecoder.sv
module flashWpDecoder
  import wpDecodePkg::*;
#(
  parameter int PROT_BITS  = 3,
  parameter int GRAN_SHIFT = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  statusLo,
  input  logic [7:0]  statusHi,
  input  logic [31:0] flashBytes,
  input  logic [31:0] qryStart,
  input  logic [31:0] qryLen,
  output logic [31:0] protOffset,
  output logic [31:0] protSize,
  output logic        covered,
  output logic        protErr
);

  wpStrobes_t           ctl;
  logic [PROT_BITS-1:0] protField;

  wpCtrl #(.PROT_BITS(PROT_BITS)) uCtrl (
    .statusLo (statusLo),
    .statusHi (statusHi),
    .protField(protField),
    .ctl      (ctl)
  );

  wpDatapath #(.PROT_BITS(PROT_BITS), .GRAN_SHIFT(GRAN_SHIFT)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .protField (protField),
    .flashBytes(flashBytes),
    .qryStart  (qryStart),
    .qryLen    (qryLen),
    .protOffset(protOffset),
    .protSize  (protSize),
    .covered   (covered),
    .protErr   (protErr)
  );

endmodule

// File: tb/tb_flashWpDecoder.sv
module tb_flashWpDecoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  sLo = '0;
  logic [7:0]  sHi = '0;
  logic [31:0] dev = 32'h0100_0000;
  logic [31:0] qs = '0;
  logic [31:0] ql = '0;
  logic [31:0] off3, size3, off4, size4;
  logic        cov3, err3, cov4, err4;
  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;  // 50 MHz

  flashWpDecoder #(.PROT_BITS(3), .GRAN_SHIFT(16)) dut (
    .clk(clk), .rstN(rstN), .statusLo(sLo), .statusHi(sHi), .flashBytes(dev),
    .qryStart(qs), .qryLen(ql), .protOffset(off3), .protSize(size3),
    .covered(cov3), .protErr(err3));

  flashWpDecoder #(.PROT_BITS(4), .GRAN_SHIFT(16)) dut4 (
    .clk(clk), .rstN(rstN), .statusLo(sLo), .statusHi(sHi), .flashBytes(dev),
    .qryStart(qs), .qryLen(ql), .protOffset(off4), .protSize(size4),
    .covered(cov4), .protErr(err4));

  task automatic checkVal(input string tag, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Reference built from the requirement text
  task automatic model(input int bits, input logic [7:0] s1, input logic [7:0] s2,
                       input logic [31:0] d, input logic [31:0] a, input logic [31:0] n,
                       output logic [31:0] eOff, output logic [31:0] eSize,
                       output logic eCov, output logic eErr);
    int lvl;
    logic tb;
    logic [63:0] raw;
    lvl = (bits == 3) ? int'(s1[4:2]) : int'(s1[5:2]);
    tb  = (bits == 3) ? s1[5] : s1[6];
    eErr = (bits == 3) && s1[6];
    if (eErr) begin
      eOff = 0; eSize = 0; eCov = 0;
    end else begin
      raw = (lvl == 0) ? 64'd0 : (64'h1_0000 << (lvl - 1));
      if (raw > {32'd0, d}) raw = {32'd0, d};
      if (s2[6]) begin
        raw = {32'd0, d} - raw;
        tb = !tb;
      end
      eSize = raw[31:0];
      eOff = tb ? 32'd0 : d - eSize;
      eCov = (eSize != 0) && (a >= eOff) &&
             ({32'd0, a} + {32'd0, n} <= {32'd0, eOff} + {32'd0, eSize});
    end
  endtask

  task automatic applyAndCompare(input string tag, input logic [7:0] s1, input logic [7:0] s2,
                                 input logic [31:0] d, input logic [31:0] a, input logic [31:0] n);
    logic [31:0] eo, es;
    logic ec, ee;
    @(negedge clk);
    sLo = s1; sHi = s2; dev = d; qs = a; ql = n;
    @(negedge clk);
    model(3, s1, s2, d, a, n, eo, es, ec, ee);
    checkVal(tag, "off3", off3, eo);
    checkVal(tag, "size3", size3, es);
    checkVal(tag, "cov3", 32'(cov3), 32'(ec));
    checkVal(tag, "err3", 32'(err3), 32'(ee));
    model(4, s1, s2, d, a, n, eo, es, ec, ee);
    checkVal(tag, "off4", off4, eo);
    checkVal(tag, "size4", size4, es);
    checkVal(tag, "cov4", 32'(cov4), 32'(ec));
    checkVal(tag, "err4", 32'(err4), 32'(ee));
  endtask

  task automatic t_reset_r1();
    @(negedge clk);
    checkVal("R1", "off3", off3, 0);
    checkVal("R1", "size3", size3, 0);
    checkVal("R1", "cov3", 32'(cov3), 0);
    checkVal("R1", "err4", 32'(err4), 0);
  endtask

  task automatic t_zero_r2();
    applyAndCompare("R2", 8'h00, 8'h00, 32'h0100_0000, 32'h0, 32'h10);
    checkVal("R2", "size3 literal", size3, 0);
    checkVal("R2", "cov3 literal", 32'(cov3), 0);
  endtask

  task automatic t_sizes_r3();
    for (int l = 1; l < 8; l++)
      applyAndCompare("R3", 8'(l << 2), 8'h00, 32'h0100_0000, 32'h0, 32'h0);
    applyAndCompare("R3", 8'h0C, 8'h00, 32'h0100_0000, 32'h0, 32'h0);
    checkVal("R3", "size3 L3", size3, 32'h0004_0000);
    applyAndCompare("R3", 8'h1C, 8'h00, 32'h0010_0000, 32'h0, 32'h0);
    checkVal("R3", "size3 clipped", size3, 32'h0010_0000);
    checkVal("R3", "off3 clipped", off3, 32'h0);
  endtask

  task automatic t_complement_r4();
    applyAndCompare("R4", 8'h08, 8'h40, 32'h0100_0000, 32'h0, 32'h0);
    checkVal("R4", "size3", size3, 32'h00FE_0000);
    checkVal("R4", "off3", off3, 32'h0);
    applyAndCompare("R4", 8'h00, 8'h40, 32'h0100_0000, 32'h0, 32'h0100_0000);
    checkVal("R4", "size3 full", size3, 32'h0100_0000);
    checkVal("R4", "cov3 full", 32'(cov3), 1);
  endtask

  task automatic t_offset_r5();
    applyAndCompare("R5", 8'h0C, 8'h00, 32'h0100_0000, 32'h0, 32'h0);
    checkVal("R5", "off3 top", off3, 32'h00FC_0000);
    applyAndCompare("R5", 8'h2C, 8'h00, 32'h0100_0000, 32'h0, 32'h0);
    checkVal("R5", "off3 bottom", off3, 32'h0);
    applyAndCompare("R5", 8'h2C, 8'h40, 32'h0100_0000, 32'h0, 32'h0);
    checkVal("R5", "off3 cmp", off3, 32'h0004_0000);
  endtask

  task automatic t_fieldpos_r6();
    applyAndCompare("R6", 8'h24, 8'h00, 32'h0100_0000, 32'h0, 32'h0);
    checkVal("R6", "size4 L9", size4, 32'h0100_0000);
    checkVal("R6", "size3 L1", size3, 32'h0001_0000);
    checkVal("R6", "off3 bottom", off3, 32'h0);
    applyAndCompare("R6", 8'h48, 8'h00, 32'h0100_0000, 32'h0, 32'h0);
    checkVal("R6", "off4 bottom", off4, 32'h0);
  endtask

  task automatic t_sector_r7();
    applyAndCompare("R7", 8'h4C, 8'h00, 32'h0100_0000, 32'h00FC_0000, 32'h10);
    checkVal("R7", "err3", 32'(err3), 1);
    checkVal("R7", "size3", size3, 0);
    checkVal("R7", "err4", 32'(err4), 0);
    checkVal("R7", "size4", size4, 32'h0004_0000);
  endtask

  task automatic t_covered_r8();
    applyAndCompare("R8", 8'h0C, 8'h00, 32'h0100_0000, 32'h00FC_0000, 32'h0004_0000);
    checkVal("R8", "exact fit", 32'(cov3), 1);
    applyAndCompare("R8", 8'h0C, 8'h00, 32'h0100_0000, 32'h00FB_FFFF, 32'h2);
    checkVal("R8", "starts below", 32'(cov3), 0);
    applyAndCompare("R8", 8'h0C, 8'h00, 32'h0100_0000, 32'h00FC_0000, 32'h0004_0001);
    checkVal("R8", "ends beyond", 32'(cov3), 0);
    applyAndCompare("R8", 8'h0C, 8'h00, 32'h0100_0000, 32'hFFFF_FFF0, 32'h0000_0020);
    checkVal("R8", "wraps", 32'(cov3), 0);
  endtask

  task automatic t_latency_r9();
    applyAndCompare("R9", 8'h04, 8'h00, 32'h0100_0000, 32'h0, 32'h0);
    @(negedge clk);
    sLo = 8'h10;
    #2;
    checkVal("R9", "size3 before edge", size3, 32'h0001_0000);
    @(negedge clk);
    checkVal("R9", "size3 after edge", size3, 32'h0008_0000);
  endtask

  task automatic t_ignored_r10();
    applyAndCompare("R10", 8'h0C, 8'h00, 32'h0100_0000, 32'h00FC_0000, 32'h100);
    applyAndCompare("R10", 8'h8F, 8'hBF, 32'h0100_0000, 32'h00FC_0000, 32'h100);
    checkVal("R10", "off3", off3, 32'h00FC_0000);
    checkVal("R10", "size3", size3, 32'h0004_0000);
    checkVal("R10", "cov3", 32'(cov3), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset_r1();
    @(negedge clk);
    rstN = 1'b1;
    t_zero_r2();
    t_sizes_r3();
    t_complement_r4();
    t_offset_r5();
    t_fieldpos_r6();
    t_sector_r7();
    t_covered_r8();
    t_latency_r9();
    t_ignored_r10();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule